// File: doc/BRIEF.md
# Dual-Channel Synthesizer Serial Programming Loader

This block programs two independent frequency-synthesizer channels through one three-wire serial port: a data line, a shift clock and a load strobe. All three inputs are sampled by the block's own clock and must be synchronous to it. Each rising edge of the shift clock pushes one data bit into a single shared shift chain. The three bits shifted in last are control bits, and they steer the word that sits above them in the chain.

A rising edge of the load strobe copies the steered fields into one of four latch sets: the reference divider or the combined N/A dividers, of channel 1 or of channel 2. The same load also updates the addressed channel's switch output. The far end of the chain is brought out on a serial output, so the programmed stream can be read back or passed on to a cascaded register. Frames may carry leading don't-care padding, which lets a byte-oriented host always send 24 bits.

Top module: `serial_synth_loader`

## Requirements
- R1: Each rising edge of `ser_clk_i` shifts `ser_data_i` into a 20-bit chain, and `ser_out_o` shows the bit that was shifted in 20 shift edges earlier. After reset `ser_out_o` is 0.
- R2: The last bit shifted (chain bit 0) selects the channel: 1 loads channel 1 and 0 loads channel 2. The other channel's outputs are left unchanged.
- R3: The next-to-last bit (chain bit 1) sets the addressed channel's switch. A 0 asserts `chN_sw_pull_o`, which pulls low. A 1 releases it, which is the high-impedance state.
- R4: The third-from-last bit (chain bit 2) selects the latch group. With 0, the N and A latches load and R is kept: N is 10 bits, sent first and MSB first, followed by A as 7 bits, MSB first. With 1, the 14-bit R latch loads from the 14 bits sent before the control bits, MSB first, and N and A are kept.
- R5: Leading don't-care bits have no effect on the loaded values. This covers up to 4 such bits before an N/A frame and up to 7 before a reference frame, making a 24-bit frame.
- R6: While no load edge occurs, shifting any number of bits leaves every latched output unchanged.
- R7: After reset, all R, N and A outputs are 0 and both switch outputs are released (pull = 0).
- R8: A transfer happens only on the rising edge of `ser_load_i`. Holding the load input high while more bits are shifted in, and later lowering it, causes no further transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk_i | input | 1 | Serial shift clock (sampled) |
| ser_data_i | input | 1 | Serial data bit |
| ser_load_i | input | 1 | Load strobe; rising edge transfers |
| ser_out_o | output | 1 | Far end of the shift chain |
| ch1_r_o | output | 14 | Channel 1 reference divider |
| ch1_n_o | output | 10 | Channel 1 N divider |
| ch1_a_o | output | 7 | Channel 1 A divider |
| ch1_sw_pull_o | output | 1 | Channel 1 switch pull-low enable |
| ch2_r_o | output | 14 | Channel 2 reference divider |
| ch2_n_o | output | 10 | Channel 2 N divider |
| ch2_a_o | output | 7 | Channel 2 A divider |
| ch2_sw_pull_o | output | 1 | Channel 2 switch pull-low enable |

## Verification
The hardest case to reach is a load strobe that stays high across further shifting. In that case the chain changes under a raised strobe, and only the edge may cause a transfer. The bench pulses a valid frame in, keeps the strobe raised, shifts a second, conflicting frame, then drops the strobe and checks that every output still matches the first frame. Padded 24-bit frames with non-zero filler bits put garbage past the far end of the chain, and the bench compares `ser_out_o` against the bit sent 20 edges earlier.

// File: rtl/sslp_pkg.sv
package sslp_pkg;
    localparam int R_W     = 14;
    localparam int N_W     = 10;
    localparam int A_W     = 7;
    localparam int CTRL_W  = 3;
    localparam int CHAIN_W = N_W + A_W + CTRL_W;
    localparam int CH_BIT  = 0;   // 1 = channel 1, 0 = channel 2
    localparam int SW_BIT  = 1;   // 0 = pull low, 1 = released
    localparam int GRP_BIT = 2;   // 0 = N/A latches, 1 = R latch
    localparam int NUM_CH  = 2;

    typedef struct packed {
        logic [R_W-1:0] r;
        logic [N_W-1:0] n;
        logic [A_W-1:0] a;
        logic           sw_off;
    } chan_cfg_t;
endpackage

// File: rtl/sslp_rise.sv
module sslp_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o
);
    typedef struct packed {
        logic prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = lvl_i & ~st_q.prev;
endmodule

// File: rtl/sslp_chain.sv
module sslp_chain
    import sslp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_i,
    input  logic               bit_i,
    output logic [CHAIN_W-1:0] chain_o,
    output logic               sout_o
);
    typedef struct packed {
        logic [CHAIN_W-1:0] sr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_i) st_d.sr = {st_q.sr[CHAIN_W-2:0], bit_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign chain_o = st_q.sr;
    assign sout_o  = st_q.sr[CHAIN_W-1];
endmodule

// File: rtl/sslp_chan_bank.sv
module sslp_chan_bank
    import sslp_pkg::*;
#(
    parameter logic CH_CODE = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [CHAIN_W-1:0] chain_i,
    output chan_cfg_t          cfg_o
);
    localparam chan_cfg_t RST_CFG = '{r: '0, n: '0, a: '0, sw_off: 1'b1};

    chan_cfg_t cfg_d, cfg_q;
    logic      hit;

    assign hit = load_i && (chain_i[CH_BIT] == CH_CODE);

    always_comb begin
        cfg_d = cfg_q;
        if (hit) begin
            cfg_d.sw_off = chain_i[SW_BIT];
            if (chain_i[GRP_BIT]) begin
                cfg_d.r = chain_i[CTRL_W +: R_W];
            end else begin
                cfg_d.a = chain_i[CTRL_W +: A_W];
                cfg_d.n = chain_i[CTRL_W + A_W +: N_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= RST_CFG;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/serial_synth_loader.sv
module serial_synth_loader
    import sslp_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ser_clk_i,
    input  logic           ser_data_i,
    input  logic           ser_load_i,
    output logic           ser_out_o,
    output logic [R_W-1:0] ch1_r_o,
    output logic [N_W-1:0] ch1_n_o,
    output logic [A_W-1:0] ch1_a_o,
    output logic           ch1_sw_pull_o,
    output logic [R_W-1:0] ch2_r_o,
    output logic [N_W-1:0] ch2_n_o,
    output logic [A_W-1:0] ch2_a_o,
    output logic           ch2_sw_pull_o
);
    logic               shift_rise;
    logic               load_rise;
    logic [CHAIN_W-1:0] chain_q;
    chan_cfg_t          cfg [NUM_CH];

    sslp_rise u_clk_rise (
        .clk(clk), .rst_n(rst_n), .lvl_i(ser_clk_i), .rise_o(shift_rise)
    );

    sslp_rise u_load_rise (
        .clk(clk), .rst_n(rst_n), .lvl_i(ser_load_i), .rise_o(load_rise)
    );

    sslp_chain u_chain (
        .clk(clk), .rst_n(rst_n), .shift_i(shift_rise), .bit_i(ser_data_i),
        .chain_o(chain_q), .sout_o(ser_out_o)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_bank
        sslp_chan_bank #(.CH_CODE((g == 0) ? 1'b1 : 1'b0)) u_bank (
            .clk(clk), .rst_n(rst_n), .load_i(load_rise),
            .chain_i(chain_q), .cfg_o(cfg[g])
        );
    end

    assign ch1_r_o       = cfg[0].r;
    assign ch1_n_o       = cfg[0].n;
    assign ch1_a_o       = cfg[0].a;
    assign ch1_sw_pull_o = ~cfg[0].sw_off;
    assign ch2_r_o       = cfg[1].r;
    assign ch2_n_o       = cfg[1].n;
    assign ch2_a_o       = cfg[1].a;
    assign ch2_sw_pull_o = ~cfg[1].sw_off;
endmodule

// File: rtl/sslp_checker.sv
module sslp_checker
    import sslp_pkg::*;
(
    input logic                       clk,
    input logic                       rst_n,
    input logic                       ser_clk_i,
    input logic                       ser_load_i,
    input logic                       ser_out_o,
    input logic [CHAIN_W-1:0]         chain,
    input logic [R_W+N_W+A_W:0]       ch1,
    input logic [R_W+N_W+A_W:0]       ch2
);
    logic sc_prev_q, ld_prev_q;
    logic sc_rise, ld_rise;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_prev_q <= 1'b0;
            ld_prev_q <= 1'b0;
        end else begin
            sc_prev_q <= ser_clk_i;
            ld_prev_q <= ser_load_i;
        end
    end

    assign sc_rise = ser_clk_i & ~sc_prev_q;
    assign ld_rise = ser_load_i & ~ld_prev_q;

    AST_SOUT_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        sc_rise |=> ser_out_o == $past(chain[CHAIN_W-2])); // R1
    AST_CH1_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_rise && !chain[CH_BIT]) |=> $stable(ch1)); // R2
    AST_CH2_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_rise && chain[CH_BIT]) |=> $stable(ch2)); // R2
    AST_SW_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_rise && chain[CH_BIT]) |=> ch1[0] == !$past(chain[SW_BIT])); // R3
    AST_REF_KEEPS_NA: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_rise && chain[GRP_BIT]) |=> $stable(ch1[N_W+A_W:1]) && $stable(ch2[N_W+A_W:1])); // R4
    AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_rise |=> $stable(ch1) && $stable(ch2)); // R6
endmodule

bind serial_synth_loader sslp_checker u_chk (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk_i), .ser_load_i(ser_load_i),
    .ser_out_o(ser_out_o), .chain(chain_q),
    .ch1({ch1_r_o, ch1_n_o, ch1_a_o, ch1_sw_pull_o}),
    .ch2({ch2_r_o, ch2_n_o, ch2_a_o, ch2_sw_pull_o})
);

// File: tb/serial_synth_loader_tb_top.sv
module serial_synth_loader_tb_top;
    import sslp_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
    logic ser_out;
    logic [R_W-1:0] c1r, c2r;
    logic [N_W-1:0] c1n, c2n;
    logic [A_W-1:0] c1a, c2a;
    logic c1p, c2p;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [R_W-1:0] er [2];
    logic [N_W-1:0] en [2];
    logic [A_W-1:0] ea [2];
    logic           ep [2];

    always #4 clk = ~clk;

    serial_synth_loader dut_i (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_data_i(ser_data),
        .ser_load_i(ser_load), .ser_out_o(ser_out),
        .ch1_r_o(c1r), .ch1_n_o(c1n), .ch1_a_o(c1a), .ch1_sw_pull_o(c1p),
        .ch2_r_o(c2r), .ch2_n_o(c2n), .ch2_a_o(c2a), .ch2_sw_pull_o(c2p)
    );

    typedef struct packed {
        logic [4:0]  len;
        logic [23:0] bits;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{5'd20, {4'h0, 10'd357, 7'd93,  1'b0, 1'b0, 1'b1}},
        '{5'd17, {7'h00, 14'd9001,       1'b1, 1'b0, 1'b0}},
        '{5'd24, {4'hA, 10'd1023, 7'd0,  1'b0, 1'b1, 1'b0}},
        '{5'd24, {7'h5B, 14'd16383,      1'b1, 1'b1, 1'b1}},
        '{5'd20, {4'h0, 10'd3, 7'd127,   1'b0, 1'b0, 1'b0}},
        '{5'd17, {7'h00, 14'd3,          1'b1, 1'b0, 1'b1}},
        '{5'd24, {4'hF, 10'd512, 7'd64,  1'b0, 1'b1, 1'b1}},
        '{5'd24, {7'h7F, 14'd4660,       1'b1, 1'b1, 1'b0}}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check(req, "ch1_r", 32'(c1r), 32'(er[0]));
        check(req, "ch1_n", 32'(c1n), 32'(en[0]));
        check(req, "ch1_a", 32'(c1a), 32'(ea[0]));
        check(req, "ch1_pull", 32'(c1p), 32'(ep[0]));
        check(req, "ch2_r", 32'(c2r), 32'(er[1]));
        check(req, "ch2_n", 32'(c2n), 32'(en[1]));
        check(req, "ch2_a", 32'(c2a), 32'(ea[1]));
        check(req, "ch2_pull", 32'(c2p), 32'(ep[1]));
    endtask

    task automatic shift_frame(input logic [23:0] bits, input int len);
        for (int i = len - 1; i >= 0; i--) begin
            @(negedge clk); ser_clk = 1'b0; ser_data = bits[i];
            @(negedge clk);
            @(negedge clk); ser_clk = 1'b1;
            @(negedge clk);
        end
        @(negedge clk); ser_clk = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_load();
        @(negedge clk); ser_load = 1'b1;
        @(negedge clk);
        @(negedge clk); ser_load = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // expected update from the frame's last 20 bits per R2, R3, R4
    task automatic model_load(input logic [23:0] bits);
        int ch;
        ch = bits[0] ? 0 : 1;
        ep[ch] = ~bits[1];
        if (bits[2]) er[ch] = bits[16:3];
        else begin
            ea[ch] = bits[9:3];
            en[ch] = bits[19:10];
        end
    endtask

    initial begin
        for (int c = 0; c < 2; c++) begin
            er[c] = '0; en[c] = '0; ea[c] = '0; ep[c] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R7");
        check("R7", "sout", 32'(ser_out), 32'd0);

        for (int v = 0; v < NV; v++) begin
            shift_frame(VEC[v].bits, int'(VEC[v].len));
            if (VEC[v].len >= 5'd20)
                check("R1", "sout", 32'(ser_out), 32'(VEC[v].bits[19]));
            pulse_load();
            model_load(VEC[v].bits);
            check_all(VEC[v].len == 5'd24 ? "R5" : (VEC[v].bits[2] ? "R4" : "R2"));
        end

        // R6: shift a full frame with no load edge
        shift_frame({4'h0, 10'd1, 7'd1, 1'b0, 1'b0, 1'b1}, 20);
        check_all("R6");

        // R8: load held high across a second frame, then lowered
        shift_frame({7'h00, 14'd77, 1'b1, 1'b0, 1'b1}, 17);
        @(negedge clk); ser_load = 1'b1;
        @(negedge clk);
        model_load({7'h00, 14'd77, 1'b1, 1'b0, 1'b1});
        shift_frame({4'h0, 10'd200, 7'd5, 1'b0, 1'b1, 1'b1}, 20);
        check_all("R8");
        @(negedge clk); ser_load = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_all("R8");

        // R3: release ch2 switch via a reference frame, then pull again
        shift_frame({7'h00, 14'd11, 1'b1, 1'b1, 1'b0}, 17);
        pulse_load();
        model_load({7'h00, 14'd11, 1'b1, 1'b1, 1'b0});
        check("R3", "ch2_pull", 32'(c2p), 32'(ep[1]));
        shift_frame({7'h00, 14'd12, 1'b1, 1'b0, 1'b0}, 17);
        pulse_load();
        model_load({7'h00, 14'd12, 1'b1, 1'b0, 1'b0});
        check("R3", "ch2_pull", 32'(c2p), 32'(ep[1]));
        check_all("R3");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule